// File: doc/BRIEF.md
# Static Memory Read Timing Generator

This block runs one read access on an external asynchronous static memory. A request carries a byte address, and a set of timing fields is sampled with it. The block then drives the external address and produces an active-low read strobe and an active-low chip select. Each strobe has its own programmable delay and low time. Both sit inside one programmable overall cycle length, and all of these are counted in cycles of the block clock.

The read word is taken from the data bus on the clock edge at which the read strobe goes high. It is returned together with a one-cycle done pulse. A configured device width of 8, 16 or 32 bits sets two things: which low address bits reach the memory, and which byte selects are driven. The returned word is zero-extended from the device width to 32 bits. While a cycle is in progress the block reports busy, and it ignores new requests.

Top module: `sram_rd_sequencer`

## Requirements
- R1: The external address is driven from the first cycle of an access and stays unchanged until the access ends. The width field is encoded as 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. For an 8-bit device the full byte address is driven. For a 16-bit device address bit 0 is driven as 0. For a 32-bit device bits 1 and 0 are driven as 0.
- R2: Cycles of an access are numbered from 0. The read strobe is low exactly in cycles rd_setup up to rd_setup+rd_pulse-1. A zero rd_pulse acts as 1.
- R3: The chip select is low exactly in cycles cs_setup up to cs_setup+cs_pulse-1, independent of the read strobe. A zero cs_pulse acts as 1.
- R4: Busy is high for exactly N cycles, starting in the cycle after the request is sampled. N is the largest of cycle_len, rd_setup+rd_pulse and cs_setup+cs_pulse, each pulse taken after the zero-to-one rule.
- R5: The data bus is captured on the clock edge that ends the read strobe's last low cycle. An 8-bit device returns data bits 7:0 zero-extended, a 16-bit device returns bits 15:0 zero-extended, and a 32-bit device returns all 32 bits.
- R6: Done is high for exactly one cycle, the first cycle after busy falls. The read word is valid in that cycle and is held until the next capture.
- R7: A request raised while busy is high is ignored. It starts no access and does not change the driven address.
- R8: Outside an access the read strobe, chip select and all four byte selects are high. During an access the byte selects are low for the lanes the device width uses: none for 8-bit, bits 1:0 for 16-bit, bits 3:0 for 32-bit.
- R9: A request raised in the done cycle is accepted, and the new access starts in the next cycle.
- R10: After reset the strobes and byte selects are high, busy and done are low, and the read word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing is counted in it |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a read access when not busy |
| req_addr_i | input | ADDR_W | Byte address of the access |
| cfg_width_i | input | 2 | Device data width code |
| cfg_rd_setup_i | input | CNT_W | Cycles from address valid to read strobe low |
| cfg_rd_pulse_i | input | CNT_W | Read strobe low time in cycles |
| cfg_cs_setup_i | input | CNT_W | Cycles from address valid to chip select low |
| cfg_cs_pulse_i | input | CNT_W | Chip select low time in cycles |
| cfg_cycle_i | input | CNT_W | Requested total access length in cycles |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse when the read word is valid |
| rdata_o | output | 32 | Returned, zero-extended read word |
| mem_addr_o | output | ADDR_W | External address bus |
| mem_rd_n_o | output | 1 | Active-low read strobe |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_bs_n_o | output | 4 | Active-low byte selects |
| mem_data_i | input | 32 | External data bus |

## Verification
Two events can land in the same clock cycle: the done pulse of one access and the acceptance of the next request. The bench provokes this by chaining the table's accesses back to back, raising each request in the done cycle of the access before it. For each chained access it checks three things: the earlier word and the done pulse are correct in that cycle, busy rises in the very next cycle, and the new strobe timing counts from that point. The memory model drives valid data only while the read strobe is low. Because of that, a capture made one edge late returns a marker word instead of the data.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

    typedef enum logic [1:0] {
        DW_8    = 2'd0,
        DW_16   = 2'd1,
        DW_32   = 2'd2,
        DW_32_A = 2'd3
    } dev_width_e;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;

    // zero-extend the bus word according to device width
    function automatic logic [WORD_W-1:0] zext_word(input dev_width_e w,
                                                    input logic [WORD_W-1:0] bus);
        logic [WORD_W-1:0] r;
        case (w)
            DW_8:    r = {{(WORD_W-8){1'b0}}, bus[7:0]};
            DW_16:   r = {{(WORD_W-16){1'b0}}, bus[15:0]};
            default: r = bus;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_rd_window.sv
// One strobe: asserted while the access counter lies in [start, start+span)
module sram_rd_window #(
    parameter int CW = 7
) (
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] start_i,
    input  logic [CW-1:0] span_i,
    output logic          on_o
);
    logic [CW:0] stop;

    always_comb begin
        stop = {1'b0, start_i} + {1'b0, span_i};
        on_o = active_i && (cnt_i >= start_i) && ({1'b0, cnt_i} < stop);
    end
endmodule

// File: rtl/sram_rd_addr_map.sv
// Device-width dependent address layout and byte-select lanes
module sram_rd_addr_map
    import sram_rd_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              active_i,
    input  dev_width_e        width_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] ext_addr_o,
    output logic [LANES-1:0]  bs_n_o
);
    logic [LANES-1:0] lanes;

    always_comb begin
        ext_addr_o = addr_i;
        lanes      = '0;
        case (width_i)
            DW_8: begin
                lanes = '0;
            end
            DW_16: begin
                ext_addr_o[0] = 1'b0;
                lanes         = {{(LANES-2){1'b0}}, 2'b11};
            end
            default: begin
                ext_addr_o[1:0] = 2'b00;
                lanes           = '1;
            end
        endcase
        bs_n_o = active_i ? ~lanes : '1;
    end
endmodule

// File: rtl/sram_rd_sequencer.sv
module sram_rd_sequencer
    import sram_rd_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        cfg_width_i,
    input  logic [CNT_W-1:0]  cfg_rd_setup_i,
    input  logic [CNT_W-1:0]  cfg_rd_pulse_i,
    input  logic [CNT_W-1:0]  cfg_cs_setup_i,
    input  logic [CNT_W-1:0]  cfg_cs_pulse_i,
    input  logic [CNT_W-1:0]  cfg_cycle_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [31:0]       rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_n_o,
    output logic              mem_cs_n_o,
    output logic [3:0]        mem_bs_n_o,
    input  logic [31:0]       mem_data_i
);
    localparam int LW      = CNT_W + 1;   // holds setup+pulse
    localparam int NSTROBE = 2;           // 0: read strobe, 1: chip select

    typedef struct packed {
        logic              active;
        logic              done;
        logic [LW-1:0]     cnt;
        logic [LW-1:0]     len;
        logic [LW-1:0]     rd_end;
        logic [LW-1:0]     rd_start;
        logic [LW-1:0]     rd_span;
        logic [LW-1:0]     cs_start;
        logic [LW-1:0]     cs_span;
        dev_width_e        width;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] rdata;
    } seq_t;

    typedef struct packed {
        logic              rd_n;
        logic              cs_n;
        logic [LANES-1:0]  bs_n;
        logic [ADDR_W-1:0] addr;
    } pin_t;

    seq_t st_d, st_q;
    pin_t pin_d, pin_q;

    logic [LW-1:0] rp_eff, cp_eff, rd_sum, cs_sum, cyc_ext, len_calc;
    logic [LW-1:0] win_start [NSTROBE];
    logic [LW-1:0] win_span  [NSTROBE];
    logic [NSTROBE-1:0] win_on;
    logic [ADDR_W-1:0]  map_addr;
    logic [LANES-1:0]   map_bs_n;

    // effective timing of the incoming request
    always_comb begin
        rp_eff   = (cfg_rd_pulse_i == '0) ? LW'(1) : LW'(cfg_rd_pulse_i);
        cp_eff   = (cfg_cs_pulse_i == '0) ? LW'(1) : LW'(cfg_cs_pulse_i);
        rd_sum   = LW'(cfg_rd_setup_i) + rp_eff;
        cs_sum   = LW'(cfg_cs_setup_i) + cp_eff;
        cyc_ext  = LW'(cfg_cycle_i);
        len_calc = cyc_ext;
        if (rd_sum > len_calc) len_calc = rd_sum;
        if (cs_sum > len_calc) len_calc = cs_sum;
    end

    // sequencing state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (req_i) begin
                st_d.active   = 1'b1;
                st_d.cnt      = '0;
                st_d.len      = len_calc;
                st_d.rd_end   = rd_sum;
                st_d.rd_start = LW'(cfg_rd_setup_i);
                st_d.rd_span  = rp_eff;
                st_d.cs_start = LW'(cfg_cs_setup_i);
                st_d.cs_span  = cp_eff;
                st_d.width    = dev_width_e'(cfg_width_i);
                st_d.addr     = req_addr_i;
            end
        end else begin
            if (st_q.cnt == st_q.len - LW'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + LW'(1);
            end
            if (st_q.cnt == st_q.rd_end - LW'(1)) begin
                st_d.rdata = zext_word(st_q.width, mem_data_i);
            end
        end
    end

    // strobe windows evaluated on the next state
    always_comb begin
        win_start[0] = st_d.rd_start;
        win_span[0]  = st_d.rd_span;
        win_start[1] = st_d.cs_start;
        win_span[1]  = st_d.cs_span;
    end

    for (genvar g = 0; g < NSTROBE; g++) begin : g_win
        sram_rd_window #(.CW(LW)) u_win (
            .active_i (st_d.active),
            .cnt_i    (st_d.cnt),
            .start_i  (win_start[g]),
            .span_i   (win_span[g]),
            .on_o     (win_on[g])
        );
    end

    sram_rd_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .active_i   (st_d.active),
        .width_i    (st_d.width),
        .addr_i     (st_d.addr),
        .ext_addr_o (map_addr),
        .bs_n_o     (map_bs_n)
    );

    always_comb begin
        pin_d.rd_n = ~win_on[0];
        pin_d.cs_n = ~win_on[1];
        pin_d.bs_n = map_bs_n;
        pin_d.addr = map_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            pin_q.rd_n <= 1'b1;
            pin_q.cs_n <= 1'b1;
            pin_q.bs_n <= '1;
            pin_q.addr <= '0;
        end else begin
            st_q  <= st_d;
            pin_q <= pin_d;
        end
    end

    assign busy_o     = st_q.active;
    assign done_o     = st_q.done;
    assign rdata_o    = st_q.rdata;
    assign mem_addr_o = pin_q.addr;
    assign mem_rd_n_o = pin_q.rd_n;
    assign mem_cs_n_o = pin_q.cs_n;
    assign mem_bs_n_o = pin_q.bs_n;

    AST_IDLE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_rd_n_o && mem_cs_n_o && (&mem_bs_n_o))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R1
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt < st_q.len)); // R4
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i && (st_q.cnt != st_q.len - LW'(1))) |=> busy_o); // R7

endmodule

// File: tb/sram_rd_sequencer_tb.sv
module sram_rd_sequencer_tb;
    localparam int ADDR_W = 26;
    localparam int CNT_W  = 6;
    localparam int NV     = 6;

    // stimulus table: address, width, rd setup/pulse, cs setup/pulse, cycle, word
    localparam int          V_ADDR [NV] = '{32'h1234567, 32'h2ABCDEF, 32'h1555555,
                                            32'h0F0F0F3, 32'h3FFFFFF, 32'h0000001};
    localparam int          V_W    [NV] = '{2, 1, 0, 2, 3, 1};
    localparam int          V_RS   [NV] = '{1, 2, 0, 3, 0, 63};
    localparam int          V_RP   [NV] = '{2, 3, 1, 0, 5, 63};
    localparam int          V_CSS  [NV] = '{0, 1, 0, 2, 3, 0};
    localparam int          V_CSP  [NV] = '{4, 5, 1, 0, 2, 1};
    localparam int          V_CYC  [NV] = '{6, 3, 1, 0, 10, 5};
    localparam logic [31:0] V_WORD [NV] = '{32'hA5C3_5A96, 32'h1357_9BDF, 32'hFEDC_BA98,
                                            32'h0123_4567, 32'h8000_0001, 32'h7E7E_8181};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        cfg_w = '0;
    logic [CNT_W-1:0]  cfg_rs = '0, cfg_rp = '0, cfg_css = '0, cfg_csp = '0, cfg_cyc = '0;
    logic              busy, done, rd_n, cs_n;
    logic [31:0]       rdata, mem_data;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        bs_n;
    logic [31:0]       cur_word = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // memory model: data valid only while read strobe is low
    assign mem_data = !rd_n ? cur_word : 32'hBAD0_BAD0;

    sram_rd_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .cfg_width_i(cfg_w), .cfg_rd_setup_i(cfg_rs), .cfg_rd_pulse_i(cfg_rp),
        .cfg_cs_setup_i(cfg_css), .cfg_cs_pulse_i(cfg_csp), .cfg_cycle_i(cfg_cyc),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .mem_addr_o(mem_addr),
        .mem_rd_n_o(rd_n), .mem_cs_n_o(cs_n), .mem_bs_n_o(bs_n), .mem_data_i(mem_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one access; request driven at the current negedge
    task automatic run_read(input int addr, input int w, input int rs, input int rp,
                            input int css, input int csp, input int cyc,
                            input logic [31:0] word, input bit inject);
        int rp_e, csp_e, len, t;
        int rd_first, rd_cnt, cs_first, cs_cnt, addr_bad, bs_bad;
        logic [ADDR_W-1:0] exp_addr;
        logic [3:0]        exp_bs;
        logic [31:0]       exp_data;
        rp_e  = (rp == 0) ? 1 : rp;
        csp_e = (csp == 0) ? 1 : csp;
        len   = cyc;
        if (rs + rp_e > len) len = rs + rp_e;
        if (css + csp_e > len) len = css + csp_e;
        exp_addr = ADDR_W'(addr);
        case (w)
            0: begin exp_bs = 4'b1111; exp_data = {24'h0, word[7:0]}; end
            1: begin exp_bs = 4'b1100; exp_data = {16'h0, word[15:0]}; exp_addr[0] = 1'b0; end
            default: begin exp_bs = 4'b0000; exp_data = word; exp_addr[1:0] = 2'b00; end
        endcase
        cur_word = word;
        req_addr = ADDR_W'(addr);
        cfg_w = 2'(w); cfg_rs = CNT_W'(rs); cfg_rp = CNT_W'(rp);
        cfg_css = CNT_W'(css); cfg_csp = CNT_W'(csp); cfg_cyc = CNT_W'(cyc);
        req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        check(busy === 1'b1, "R9 busy in cycle after request", busy, 1);
        rd_first = -1; cs_first = -1; rd_cnt = 0; cs_cnt = 0; addr_bad = 0; bs_bad = 0;
        t = 0;
        while (busy === 1'b1 && t < 300) begin
            if (rd_n === 1'b0) begin if (rd_first < 0) rd_first = t; rd_cnt++; end
            if (cs_n === 1'b0) begin if (cs_first < 0) cs_first = t; cs_cnt++; end
            if (mem_addr !== exp_addr) addr_bad++;
            if (bs_n !== exp_bs) bs_bad++;
            if (inject && t == 1) begin req = 1'b1; req_addr = ~ADDR_W'(addr); end
            if (inject && t == 2) req = 1'b0;
            @(negedge clk);
            t++;
        end
        req = 1'b0;
        check(t == len, "R4 busy length", t, len);
        check(rd_first == rs, "R2 read strobe setup", rd_first, rs);
        check(rd_cnt == rp_e, "R2 read strobe pulse", rd_cnt, rp_e);
        check(cs_first == css, "R3 chip select setup", cs_first, css);
        check(cs_cnt == csp_e, "R3 chip select pulse", cs_cnt, csp_e);
        check(addr_bad == 0, "R1 address layout and hold", mem_addr, exp_addr);
        check(bs_bad == 0, "R8 byte selects during access", bs_n, exp_bs);
        check(done === 1'b1, "R6 done after busy", done, 1);
        check(rdata === exp_data, "R5 captured data", rdata, exp_data);
        check(rd_n === 1'b1 && cs_n === 1'b1 && bs_n === 4'hF, "R8 idle strobes high",
              {rd_n, cs_n, bs_n}, 6'h3F);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy === 1'b0 && done === 1'b0, "R10 busy/done low in reset", {busy, done}, 0);
        check(rd_n === 1'b1 && cs_n === 1'b1 && bs_n === 4'hF, "R10 strobes high in reset",
              {rd_n, cs_n, bs_n}, 6'h3F);
        check(rdata === 32'h0, "R10 read word zero", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, chained back to back (R9: request in done cycle)
        for (int i = 0; i < NV; i++) begin
            run_read(V_ADDR[i], V_W[i], V_RS[i], V_RP[i], V_CSS[i], V_CSP[i], V_CYC[i],
                     V_WORD[i], 1'b0);
        end

        // done pulse lasts one cycle, word held (R6)
        @(negedge clk);
        check(done === 1'b0, "R6 done single cycle", done, 0);
        check(rdata === {16'h0, 16'h8181}, "R6 word held", rdata, 32'h8181);

        // R7 request during access ignored
        @(negedge clk);
        run_read(32'h0246802, 2, 2, 3, 1, 6, 8, 32'hC0DE_F00D, 1'b1);
        repeat (2) begin
            @(negedge clk);
            check(busy === 1'b0, "R7 no extra access", busy, 0);
        end
        check(mem_addr === 26'h0246800, "R7 address unchanged", mem_addr, 26'h0246800);

        // R5 capture edge at long setup with short pulse, isolated access
        @(negedge clk);
        run_read(32'h0000013, 0, 7, 1, 5, 4, 0, 32'h0000_005A, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule